// File: doc/BRIEF.md
# Four-Channel Serial-Write Level Latch

This block is a write-only slave on a two-wire serial bus that holds four 8-bit levels, one for each converter channel that follows it. A bus master sends a three-byte write frame: a device address carrying a write direction bit, a selector byte naming the channel, and the level byte. When the level byte is acknowledged, the block copies it into the chosen channel register. The four registers drive the parallel outputs continuously until they are overwritten.

Both bus lines are sampled on a fast system clock. Each passes through a two-stage synchronizer and is then edge-detected, so the start and stop conditions and the clock edges become single-cycle events. The block never drives the data line high. It only raises a pull-low enable while it acknowledges. The device address is a parameter.

Top module: `i2c4_dac_latch`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is asserted, all four channel outputs are 0x00 and `sda_pull_o` is 0.
- R2: A frame of START, an address byte equal to `{DEV_ADDR, 1'b0}` (default `DEV_ADDR` 7'b1001100), a selector byte, a level byte and STOP loads the level byte into the selected channel. Every byte is shifted in most significant bit first.
- R3: Selector bits [1:0] pick the channel: 0 loads `ch0_o`, 1 loads `ch1_o`, 2 loads `ch2_o` and 3 loads `ch3_o`. Bits [7:2] have no effect, and the other three channels keep their values.
- R4: After an accepted address, selector or level byte, `sda_pull_o` goes high once SCL has fallen at the end of the eighth bit. It goes low again once SCL has fallen at the end of the ninth clock, so the master reads a 0 while SCL is high in the ninth clock.
- R5: An address byte whose upper seven bits differ from `DEV_ADDR` is not acknowledged. No later byte is acknowledged until the next START or STOP, and no channel changes.
- R6: An address byte that matches but has bit 0 (read) set to 1 is not acknowledged, and no channel changes.
- R7: A channel output changes only in the same system clock cycle in which `sda_pull_o` rises for the level byte's acknowledge.
- R8: Any byte after the level byte and before STOP is not acknowledged and changes no channel.
- R9: A START in any state, including a repeated START in the middle of a frame, releases `sda_pull_o` and restarts at the address byte. A frame cut short this way changes no channel.
- R10: A STOP in any state releases `sda_pull_o` and returns to idle. A frame stopped before its level byte changes no channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| ch0_o | output | 8 | Channel 0 level |
| ch1_o | output | 8 | Channel 1 level |
| ch2_o | output | 8 | Channel 2 level |
| ch3_o | output | 8 | Channel 3 level |

## Verification
The channel register write and the start of the acknowledge drive fall on the same system clock edge. Both are decided by the SCL falling event that closes the level byte's eighth bit. The bench sends the level byte of every frame in a sweep over all four selectors, with mixed don't-care bits and several data patterns. A monitor on the falling clock edge checks that every change on a channel output happens in the cycle where `sda_pull_o` rises. The same monitor also confirms that aborted, ignored and overflow frames never produce such a change.

// File: rtl/i2c4_pkg.sv
package i2c4_pkg;

    localparam int BYTE_W  = 8;
    localparam int CH_NUM  = 4;
    localparam int CH_W    = $clog2(CH_NUM);
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        SLOT_ADDR,
        SLOT_SEL,
        SLOT_LEVEL,
        SLOT_EXTRA
    } byte_slot_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return (b[BYTE_W-1:1] == dev) && !b[0];
    endfunction

    function automatic byte_slot_e next_slot(input byte_slot_e s);
        return (s == SLOT_EXTRA) ? SLOT_EXTRA : byte_slot_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/i2c4_sync.sv
module i2c4_sync
    import i2c4_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LAST = STAGES;

    logic [LAST:0] scl_sh;
    logic [LAST:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[LAST-1:0], scl_i};
            sda_sh <= {sda_sh[LAST-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sh[LAST-1];
    assign scl_old = scl_sh[LAST];
    assign sda_now = sda_sh[LAST-1];
    assign sda_old = sda_sh[LAST];

    always_comb begin
        evt.scl_rise = scl_now && !scl_old;
        evt.scl_fall = !scl_now && scl_old;
        evt.start    = scl_now && scl_old && sda_old && !sda_now;
        evt.stop     = scl_now && scl_old && !sda_old && sda_now;
        evt.sda      = sda_now;
    end
endmodule

// File: rtl/i2c4_rx.sv
module i2c4_rx
    import i2c4_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001100
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    output logic              ack_pull,
    output logic              wr_stb,
    output logic [CH_W-1:0]   wr_sel,
    output logic [BYTE_W-1:0] wr_data
);
    rx_state_e         state;
    byte_slot_e        slot;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [CH_W-1:0]   sel_q;
    logic              byte_end;

    assign byte_end = (state == ST_RECV) && (bitcnt == CNT_W'(BYTE_W))
                      && evt.scl_fall && !evt.start && !evt.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            slot   <= SLOT_ADDR;
            bitcnt <= '0;
            shreg  <= '0;
            sel_q  <= '0;
        end else if (evt.start) begin
            state  <= ST_RECV;
            slot   <= SLOT_ADDR;
            bitcnt <= '0;
        end else if (evt.stop) begin
            state  <= ST_IDLE;
        end else begin
            case (state)
                ST_RECV: begin
                    if (evt.scl_rise && bitcnt != CNT_W'(BYTE_W)) begin
                        shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        case (slot)
                            SLOT_ADDR:  state <= addr_hit(shreg, DEV_ADDR) ? ST_ACK : ST_SKIP;
                            SLOT_SEL: begin
                                sel_q <= shreg[CH_W-1:0];
                                state <= ST_ACK;
                            end
                            SLOT_LEVEL: state <= ST_ACK;
                            default:    state <= ST_SKIP;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (evt.scl_fall) begin
                        state  <= ST_RECV;
                        bitcnt <= '0;
                        slot   <= next_slot(slot);
                    end
                end
                default: ;
            endcase
        end
    end

    assign ack_pull = (state == ST_ACK);
    assign wr_stb   = byte_end && (slot == SLOT_LEVEL);
    assign wr_sel   = sel_q;
    assign wr_data  = shreg;
endmodule

// File: rtl/i2c4_latch_bank.sv
module i2c4_latch_bank
    import i2c4_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_stb,
    input  logic [CH_W-1:0]                wr_sel,
    input  logic [BYTE_W-1:0]              wr_data,
    output logic [CH_NUM-1:0]              wr_en,
    output logic [CH_NUM-1:0][BYTE_W-1:0]  q
);
    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        assign wr_en[c] = wr_stb && (wr_sel == CH_W'(c));

        always_ff @(posedge clk) begin
            if (rst)
                q[c] <= '0;
            else if (wr_en[c])
                q[c] <= wr_data;
        end
    end
endmodule

// File: rtl/i2c4_dac_latch.sv
module i2c4_dac_latch
    import i2c4_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1001100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] ch0_o,
    output logic [7:0] ch1_o,
    output logic [7:0] ch2_o,
    output logic [7:0] ch3_o
);
    bus_evt_t                          bus_evt;
    logic                              wr_stb;
    logic [CH_W-1:0]                   wr_sel;
    logic [BYTE_W-1:0]                 wr_data;
    logic [CH_NUM-1:0]                 wr_en;
    logic [CH_NUM-1:0][BYTE_W-1:0]     lvl;
    logic                              evt_start;
    logic                              evt_stop;

    i2c4_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (bus_evt)
    );

    i2c4_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .evt      (bus_evt),
        .ack_pull (sda_pull_o),
        .wr_stb   (wr_stb),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data)
    );

    i2c4_latch_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .q       (lvl)
    );

    assign evt_start = bus_evt.start;
    assign evt_stop  = bus_evt.stop;
    assign ch0_o = lvl[0];
    assign ch1_o = lvl[1];
    assign ch2_o = lvl[2];
    assign ch3_o = lvl[3];
endmodule

// File: rtl/i2c4_dac_latch_chk.sv
module i2c4_dac_latch_chk (
    input logic       clk,
    input logic       rst,
    input logic       sda_pull_o,
    input logic [7:0] ch0_o,
    input logic [7:0] ch1_o,
    input logic [7:0] ch2_o,
    input logic [7:0] ch3_o,
    input logic       wr_stb,
    input logic [3:0] wr_en,
    input logic       evt_start,
    input logic       evt_stop
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ch0_o == 8'h00 && ch1_o == 8'h00 && ch2_o == 8'h00
                 && ch3_o == 8'h00 && !sda_pull_o));

    // R3
    one_channel_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    // R7
    write_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> sda_pull_o);

    // R7
    hold_levels_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(ch0_o) && $stable(ch1_o)
                     && $stable(ch2_o) && $stable(ch3_o)));

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt_start |=> !sda_pull_o);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt_stop |=> !sda_pull_o);
endmodule

bind i2c4_dac_latch i2c4_dac_latch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull_o (sda_pull_o),
    .ch0_o      (ch0_o),
    .ch1_o      (ch1_o),
    .ch2_o      (ch2_o),
    .ch3_o      (ch3_o),
    .wr_stb     (wr_stb),
    .wr_en      (wr_en),
    .evt_start  (evt_start),
    .evt_stop   (evt_stop)
);

// File: tb/i2c4_dac_latch_tb.sv
module i2c4_dac_latch_tb;
    localparam logic [6:0] ADDR = 7'b1001100;
    localparam time Q = 40ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_pull_o;
    logic [7:0] ch0_o, ch1_o, ch2_o, ch3_o;
    logic [7:0] exp_lvl [4];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2ns clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull_o;

    i2c4_dac_latch u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull_o),
        .ch0_o(ch0_o), .ch1_o(ch1_o), .ch2_o(ch2_o), .ch3_o(ch3_o)
    );

    function automatic logic [7:0] lvl_of(input int c);
        case (c)
            0: return ch0_o;
            1: return ch1_o;
            2: return ch2_o;
            default: return ch3_o;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < 4; c++)
            chk(lvl_of(c) == exp_lvl[c], req, lvl_of(c), exp_lvl[c]);
    endtask

    // R7: any output change must coincide with a rising acknowledge drive
    logic [31:0] prev_cat;
    logic prev_pull;
    always @(negedge clk) begin
        if (!rst && {ch3_o, ch2_o, ch1_o, ch0_o} != prev_cat)
            chk(sda_pull_o && !prev_pull, "R7 change outside ack rise", sda_pull_o, 1);
        prev_cat  <= {ch3_o, ch2_o, ch1_o, ch0_o};
        prev_pull <= sda_pull_o;
    end

    task automatic bus_start;
        sda_m = 1'b1; #Q;
        scl_m = 1'b1; #Q;
        sda_m = 1'b0; #Q;
        scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; #Q;
        scl_m = 1'b1; #Q;
        sda_m = 1'b1; #(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #Q;
            scl_m = 1'b1; #(2*Q);
            scl_m = 1'b0; #Q;
        end
        sda_m = 1'b1; #Q;
        scl_m = 1'b1; #Q;
        ack = !sda_bus;
        #Q;
        scl_m = 1'b0; #Q;
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] s,
                         input logic [7:0] d, output logic [2:0] acks);
        logic k;
        bus_start;
        send_byte(a, k); acks[2] = k;
        send_byte(s, k); acks[1] = k;
        send_byte(d, k); acks[0] = k;
        bus_stop;
    endtask

    initial begin
        #2ms;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic k;
        for (int c = 0; c < 4; c++) exp_lvl[c] = 8'h00;
        repeat (6) @(posedge clk);
        #1ns;
        // R1 reset state
        chk_all("R1 reset value");
        chk(sda_pull_o == 1'b0, "R1 pull released", sda_pull_o, 0);
        rst = 1'b0;
        #(4*Q);

        // R2 R3 R4: sweep all selectors, don't-care bits and data patterns
        for (int v = 0; v < 4; v++) begin
            for (int c = 0; c < 4; c++) begin
                logic [7:0] d, s;
                d = (v == 0) ? 8'(c * 8'h40 + 8'h11) : (v == 1) ? 8'hFF :
                    (v == 2) ? 8'h00 : 8'(8'h5A ^ (c * 8'h13));
                s = {6'((v * 4 + c) * 11), 2'(c)};
                frame({ADDR, 1'b0}, s, d, acks);
                exp_lvl[c] = d;
                chk(acks == 3'b111, "R4 ack on three bytes", acks, 3'b111);
                chk_all("R2 R3 level routing");
            end
        end

        // R5 address mismatch
        frame({7'b1001111, 1'b0}, 8'h00, 8'h77, acks);
        chk(acks == 3'b000, "R5 no ack on wrong address", acks, 0);
        chk_all("R5 no change");

        // R6 read direction bit
        frame({ADDR, 1'b1}, 8'h01, 8'h66, acks);
        chk(acks == 3'b000, "R6 no ack on read", acks, 0);
        chk_all("R6 no change");

        // R8 extra byte after level byte
        bus_start;
        send_byte({ADDR, 1'b0}, k);
        send_byte(8'hFE, k);
        send_byte(8'h3C, k); chk(k == 1'b1, "R8 level byte ack", k, 1);
        send_byte(8'hC3, k); chk(k == 1'b0, "R8 extra byte nack", k, 0);
        send_byte(8'h99, k); chk(k == 1'b0, "R8 second extra nack", k, 0);
        bus_stop;
        exp_lvl[2] = 8'h3C;
        chk_all("R8 extra bytes ignored");

        // R9 repeated START after selector byte, then a full new frame
        bus_start;
        send_byte({ADDR, 1'b0}, k);
        send_byte(8'h01, k);
        sda_m = 1'b1; #Q;
        scl_m = 1'b1; #Q;
        sda_m = 1'b0; #Q;
        scl_m = 1'b0; #Q;
        chk(sda_pull_o == 1'b0, "R9 released after restart", sda_pull_o, 0);
        chk_all("R9 aborted frame no change");
        send_byte({ADDR, 1'b0}, k); chk(k == 1'b1, "R9 address after restart", k, 1);
        send_byte(8'h03, k);
        send_byte(8'hB4, k);
        bus_stop;
        exp_lvl[3] = 8'hB4;
        chk_all("R9 restarted frame writes");

        // R10 STOP before level byte
        bus_start;
        send_byte({ADDR, 1'b0}, k);
        send_byte(8'h00, k);
        bus_stop;
        chk(sda_pull_o == 1'b0, "R10 released after stop", sda_pull_o, 0);
        chk_all("R10 stopped frame no change");
        frame({ADDR, 1'b0}, 8'h00, 8'hE1, acks);
        exp_lvl[0] = 8'hE1;
        chk(acks == 3'b111, "R10 next frame acked", acks, 3'b111);
        chk_all("R10 next frame writes");

        // R5 ignored state left by STOP
        frame({7'b0001100, 1'b0}, 8'h01, 8'h12, acks);
        chk(acks == 3'b000, "R5 ignore until stop", acks, 0);
        frame({ADDR, 1'b0}, 8'h01, 8'h12, acks);
        exp_lvl[1] = 8'h12;
        chk(acks == 3'b111, "R5 recovers after stop", acks, 3'b111);
        chk_all("R5 recovers write");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule